// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one of two kinds of access: an instruction fetch or a data load/store. It holds two direct-mapped tables, one serving fetches and one serving data accesses. Each table entry is a pair of words: a tag word and a mapping word. Software-side logic fills these words through a single-word write port. A lookup indexes the chosen table with the low bits of the virtual page number. It compares the tag and checks the valid flag. It then checks the access rights that apply to the current privilege level.

A lookup is accepted through a valid/ready handshake. One cycle later it yields a response with the physical address, the granted rights and a result code. When a lookup fails, the block classifies the failure as a table miss or as a page fault, separately for fetches and for data. It records the faulting virtual address in a fault-address register and cancels any pending atomic reservation. Each table can also be switched off, in which case addresses pass through untranslated with full rights.

Top module: `mmu_xlate`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rsp_valid` and `exc_valid` are 0, `eear` is 0 and `lock_addr` is all ones.
- R2: `req_ready` is high whenever `rst` is low. A request accepted on a clock edge produces exactly one response with `rsp_valid` high in the following cycle. `rsp_valid` is low in any cycle that does not follow an accepted request.
- R3: The entry index is bits [PAGE_BITS +: IDX_BITS] of the virtual address. If tag-word bits [31:PAGE_BITS] differ from the virtual page number (address bits [31:PAGE_BITS]), the result is NOMATCH (code 1).
- R4: Bit 0 of the tag word is the valid flag. A tag hit on an entry with this flag clear gives result INVALID (code 2).
- R5: For a fetch, execute right comes from mapping-word bit 5 when `sup_mode` is 1, and from bit 2 when `sup_mode` is 0. A fetch without execute right gives result BADADDR (code 3).
- R6: For data, read and write rights come from mapping-word bits 3 and 4 when `sup_mode` is 1, and from bits 0 and 1 when `sup_mode` is 0. A read without read right, or a write without write right, gives BADADDR.
- R7: `req_kind` bit 1 set marks a fetch, which looks up the instruction table. Any other access looks up the data table. `req_kind` bit 0 set marks a write.
- R8: On success (code 0), `rsp_paddr` is mapping-word bits [31:PAGE_BITS] joined with the low PAGE_BITS of the virtual address. `rsp_rights` reports the granted rights: bit 0 read, bit 1 write, bit 2 execute.
- R9: `exc_valid` is raised with a response exactly when the result is not 0. `exc_code` is 2 for a fetch BADADDR, 3 for a data BADADDR, 0 for a fetch NOMATCH/INVALID, and 1 for a data NOMATCH/INVALID.
- R10: Every raised exception loads `eear` with the faulting virtual address and sets `lock_addr` to all ones in the same cycle. `lock_set` loads `lock_addr` from `lock_set_addr` unless an exception is raised on that edge.
- R11: When `itlb_on` (for fetches) or `dtlb_on` (for data) is 0, the result is 0, `rsp_paddr` equals the virtual address and `rsp_rights` is 7.
- R12: A table write on the same edge as an accepted lookup does not affect that lookup's response, but it does affect the next one. `tw_itable` 1 selects the instruction table, and `tw_trans` 1 selects the mapping word rather than the tag word.
- R13: On any failing response, `rsp_paddr` and `rsp_rights` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: bit 1 fetch, bit 0 write |
| sup_mode | input | 1 | Supervisor privilege active |
| itlb_on | input | 1 | Instruction translation enabled |
| dtlb_on | input | 1 | Data translation enabled |
| tw_en | input | 1 | Table write strobe |
| tw_itable | input | 1 | Write targets instruction table (1) or data table (0) |
| tw_trans | input | 1 | Write targets mapping word (1) or tag word (0) |
| tw_idx | input | 6 | Entry index to write |
| tw_data | input | 32 | Word to write |
| lock_set | input | 1 | Load a new atomic reservation address |
| lock_set_addr | input | 32 | Reservation address to load |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights: read, write, execute |
| rsp_result | output | 2 | 0 ok, 1 nomatch, 2 invalid, 3 bad address |
| exc_valid | output | 1 | Exception raised with this response |
| exc_code | output | 2 | 0 fetch miss, 1 data miss, 2 fetch fault, 3 data fault |
| eear | output | 32 | Last faulting virtual address |
| lock_addr | output | 32 | Atomic reservation address |

## Verification
The bench builds the block with its defaults: a 32-bit address, 13 offset bits and 64-entry tables. Because the index has six bits, two page numbers that differ only at bit 6 of the page number share an entry. This makes tag conflicts, valid-flag failures and rights failures easy to provoke on a single slot, in both privilege levels and for both tables. The random phase draws from eight indices and two tag values per index. It mixes writes and lookups on the same edge, so the order in which a write and a lookup take effect is checked against the bench's own model on every cycle.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NOMATCH = 2'd1,
    RES_INVALID = 2'd2,
    RES_BADADDR = 2'd3
  } xl_result_e;

  typedef enum logic [1:0] {
    EXC_IMISS  = 2'd0,
    EXC_DMISS  = 2'd1,
    EXC_IFAULT = 2'd2,
    EXC_DFAULT = 2'd3
  } xl_exc_e;

  // mapping-word permission bit positions
  localparam int unsigned PB_UR = 0;
  localparam int unsigned PB_UW = 1;
  localparam int unsigned PB_UX = 2;
  localparam int unsigned PB_SR = 3;
  localparam int unsigned PB_SW = 4;
  localparam int unsigned PB_SX = 5;
  localparam int unsigned PB_TOP = 5;

  // granted-rights vector positions
  localparam int unsigned RG_RD = 0;
  localparam int unsigned RG_WR = 1;
  localparam int unsigned RG_EX = 2;
  localparam int unsigned RG_W  = 3;

  // access kind bits
  localparam int unsigned KIND_WRITE = 0;
  localparam int unsigned KIND_FETCH = 1;

  // table numbering inside the generate loop
  localparam int unsigned TBL_DATA  = 0;
  localparam int unsigned TBL_INSTR = 1;
  localparam int unsigned N_TBL     = 2;

endpackage

// File: rtl/mmu_tlb_table.sv
module mmu_tlb_table #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned IDX_BITS = 6
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_trans,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic [WORD_W-1:0]   rd_match,
  output logic [WORD_W-1:0]   rd_trans
);
  localparam int unsigned DEPTH = 1 << IDX_BITS;

  logic [WORD_W-1:0] match_mem [DEPTH];
  logic [WORD_W-1:0] trans_mem [DEPTH];

  // single write port per word array; read is asynchronous (distributed RAM)
  always_ff @(posedge clk) begin
    if (wr_en && !wr_trans) match_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_trans) trans_mem[wr_idx] <= wr_data;
  end

  assign rd_match = match_mem[rd_idx];
  assign rd_trans = trans_mem[rd_idx];

endmodule

// File: rtl/mmu_rights_eval.sv
module mmu_rights_eval
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 13
) (
  input  logic              xl_on,
  input  logic              sup,
  input  logic              is_fetch,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] match_w,
  input  logic [ADDR_W-1:0] trans_w,
  output xl_result_e        result,
  output logic [ADDR_W-1:0] paddr,
  output logic [RG_W-1:0]   rights
);
  localparam int unsigned VPN_W = ADDR_W - PAGE_BITS;

  logic [VPN_W-1:0] vpn;
  logic             tag_hit;
  logic [RG_W-1:0]  grant;
  logic             denied;

  assign vpn     = vaddr[ADDR_W-1:PAGE_BITS];
  assign tag_hit = (match_w[ADDR_W-1:PAGE_BITS] == vpn);

  always_comb begin
    grant = '0;
    if (is_fetch) begin
      grant[RG_EX] = sup ? trans_w[PB_SX] : trans_w[PB_UX];
    end else begin
      grant[RG_RD] = sup ? trans_w[PB_SR] : trans_w[PB_UR];
      grant[RG_WR] = sup ? trans_w[PB_SW] : trans_w[PB_UW];
    end
  end

  always_comb begin
    if (is_fetch) denied = !grant[RG_EX];
    else if (is_write) denied = !grant[RG_WR];
    else denied = !grant[RG_RD];
  end

  always_comb begin
    result = RES_OK;
    paddr  = '0;
    rights = '0;
    if (!xl_on) begin
      paddr  = vaddr;
      rights = '1;
    end else if (!tag_hit) begin
      result = RES_NOMATCH;
    end else if (!match_w[0]) begin
      result = RES_INVALID;
    end else if (denied) begin
      result = RES_BADADDR;
    end else begin
      paddr  = {trans_w[ADDR_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
      rights = grant;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{match_w[PAGE_BITS-1:1], trans_w[PAGE_BITS-1:PB_TOP+1]};

endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] fire_addr,
  input  logic              lock_set,
  input  logic [ADDR_W-1:0] lock_set_addr,
  output logic [ADDR_W-1:0] eear,
  output logic [ADDR_W-1:0] lock_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eear      <= '0;
      lock_addr <= '1;
    end else if (fire) begin
      eear      <= fire_addr;
      lock_addr <= '1;
    end else if (lock_set) begin
      lock_addr <= lock_set_addr;
    end
  end

  // R10: a fault always leaves the reservation cancelled
  a_r10_fault_kills_lock: assert property (@(posedge clk) disable iff (rst)
    fire |=> (lock_addr == '1));

  // R10: the captured address is the one that faulted
  a_r10_fault_addr_held: assert property (@(posedge clk) disable iff (rst)
    fire |=> (eear == $past(fire_addr)));

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned IDX_BITS  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [1:0]          req_kind,
  input  logic                sup_mode,
  input  logic                itlb_on,
  input  logic                dtlb_on,
  input  logic                tw_en,
  input  logic                tw_itable,
  input  logic                tw_trans,
  input  logic [IDX_BITS-1:0] tw_idx,
  input  logic [ADDR_W-1:0]   tw_data,
  input  logic                lock_set,
  input  logic [ADDR_W-1:0]   lock_set_addr,
  output logic                rsp_valid,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [RG_W-1:0]     rsp_rights,
  output logic [1:0]          rsp_result,
  output logic                exc_valid,
  output logic [1:0]          exc_code,
  output logic [ADDR_W-1:0]   eear,
  output logic [ADDR_W-1:0]   lock_addr
);
  logic                accept;
  logic                is_fetch;
  logic                is_write;
  logic [IDX_BITS-1:0] look_idx;
  logic [ADDR_W-1:0]   tbl_match [N_TBL];
  logic [ADDR_W-1:0]   tbl_trans [N_TBL];
  logic [ADDR_W-1:0]   sel_match;
  logic [ADDR_W-1:0]   sel_trans;
  logic                sel_on;
  xl_result_e          ev_result;
  logic [ADDR_W-1:0]   ev_paddr;
  logic [RG_W-1:0]     ev_rights;
  xl_exc_e             ev_exc;
  logic                ev_fail;

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;
  assign is_fetch  = req_kind[KIND_FETCH];
  assign is_write  = req_kind[KIND_WRITE];
  assign look_idx  = req_vaddr[PAGE_BITS +: IDX_BITS];

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    mmu_tlb_table #(
      .WORD_W  (ADDR_W),
      .IDX_BITS(IDX_BITS)
    ) u_table (
      .clk     (clk),
      .wr_en   (tw_en && (tw_itable == 1'(t))),
      .wr_trans(tw_trans),
      .wr_idx  (tw_idx),
      .wr_data (tw_data),
      .rd_idx  (look_idx),
      .rd_match(tbl_match[t]),
      .rd_trans(tbl_trans[t])
    );
  end

  assign sel_match = is_fetch ? tbl_match[TBL_INSTR] : tbl_match[TBL_DATA];
  assign sel_trans = is_fetch ? tbl_trans[TBL_INSTR] : tbl_trans[TBL_DATA];
  assign sel_on    = is_fetch ? itlb_on : dtlb_on;

  mmu_rights_eval #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_eval (
    .xl_on   (sel_on),
    .sup     (sup_mode),
    .is_fetch(is_fetch),
    .is_write(is_write),
    .vaddr   (req_vaddr),
    .match_w (sel_match),
    .trans_w (sel_trans),
    .result  (ev_result),
    .paddr   (ev_paddr),
    .rights  (ev_rights)
  );

  assign ev_fail = (ev_result != RES_OK);

  always_comb begin
    if (ev_result == RES_BADADDR) ev_exc = is_fetch ? EXC_IFAULT : EXC_DFAULT;
    else                          ev_exc = is_fetch ? EXC_IMISS  : EXC_DMISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_rights <= '0;
      rsp_result <= RES_OK;
      exc_valid  <= 1'b0;
      exc_code   <= EXC_IMISS;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_paddr  <= ev_paddr;
      rsp_rights <= ev_rights;
      rsp_result <= ev_result;
      exc_valid  <= ev_fail;
      exc_code   <= ev_exc;
    end else begin
      rsp_valid  <= 1'b0;
      exc_valid  <= 1'b0;
    end
  end

  mmu_fault_unit #(
    .ADDR_W(ADDR_W)
  ) u_fault (
    .clk          (clk),
    .rst          (rst),
    .fire         (accept && ev_fail),
    .fire_addr    (req_vaddr),
    .lock_set     (lock_set),
    .lock_set_addr(lock_set_addr),
    .eear         (eear),
    .lock_addr    (lock_addr)
  );

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);

  a_r9_exc_matches_result: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (exc_valid == (rsp_result != RES_OK)));

  a_r9_exc_needs_rsp: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> rsp_valid);

  a_r13_fail_zeroed: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_result != RES_OK) |-> (rsp_paddr == '0 && rsp_rights == '0));

  a_r8_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_result == RES_OK) |->
      (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

  a_r10_eear_on_exc: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (eear == $past(req_vaddr) && lock_addr == '1));

endmodule

// File: tb/test_mmu_xlate.sv
`timescale 1ns/1ps
module test_mmu_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        sup_mode = 1'b0;
  logic        itlb_on = 1'b0;
  logic        dtlb_on = 1'b0;
  logic        tw_en = 1'b0;
  logic        tw_itable = 1'b0;
  logic        tw_trans = 1'b0;
  logic [5:0]  tw_idx = '0;
  logic [31:0] tw_data = '0;
  logic        lock_set = 1'b0;
  logic [31:0] lock_set_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_result;
  logic        exc_valid;
  logic [1:0]  exc_code;
  logic [31:0] eear;
  logic [31:0] lock_addr;

  always #2.5 clk = ~clk;

  mmu_xlate i_mmu_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .sup_mode(sup_mode),
    .itlb_on(itlb_on), .dtlb_on(dtlb_on), .tw_en(tw_en), .tw_itable(tw_itable),
    .tw_trans(tw_trans), .tw_idx(tw_idx), .tw_data(tw_data),
    .lock_set(lock_set), .lock_set_addr(lock_set_addr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights),
    .rsp_result(rsp_result), .exc_valid(exc_valid), .exc_code(exc_code),
    .eear(eear), .lock_addr(lock_addr)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R3";

  // bench-side table contents
  logic [31:0] m_itag [64];
  logic [31:0] m_imap [64];
  logic [31:0] m_dtag [64];
  logic [31:0] m_dmap [64];
  logic [31:0] m_eear = '0;
  logic [31:0] m_lock = '1;

  logic        e_valid = 1'b0;
  logic        e_exc = 1'b0;
  logic [1:0]  e_result = '0;
  logic [31:0] e_paddr = '0;
  logic [2:0]  e_rights = '0;
  logic [1:0]  e_code = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_lookup();
    logic [31:0] tg, mp;
    logic        fetch, wr, on, okr;
    int          idx;
    fetch = req_kind[1];
    wr    = req_kind[0];
    idx   = int'(req_vaddr[18:13]);
    tg    = fetch ? m_itag[idx] : m_dtag[idx];
    mp    = fetch ? m_imap[idx] : m_dmap[idx];
    on    = fetch ? itlb_on : dtlb_on;
    e_paddr  = 0;
    e_rights = 0;
    e_result = 0;
    if (!on) begin
      e_paddr  = req_vaddr;
      e_rights = 3'd7;
    end else if (tg[31:13] != req_vaddr[31:13]) begin
      e_result = 1;
    end else if (tg[0] == 1'b0) begin
      e_result = 2;
    end else begin
      logic r, w, x;
      r = sup_mode ? mp[3] : mp[0];
      w = sup_mode ? mp[4] : mp[1];
      x = sup_mode ? mp[5] : mp[2];
      if (fetch) okr = x;
      else if (wr) okr = w;
      else okr = r;
      if (!okr) e_result = 3;
      else begin
        e_paddr  = {mp[31:13], req_vaddr[12:0]};
        e_rights = fetch ? {x, 2'b00} : {1'b0, w, r};
      end
    end
    e_exc  = (e_result != 0);
    e_code = (e_result == 3) ? (fetch ? 2'd2 : 2'd3) : (fetch ? 2'd0 : 2'd1);
  endtask

  // one clock: update the model at the edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    #1;
    if (req_valid) begin
      e_valid = 1'b1;
      model_lookup();
    end else begin
      e_valid = 1'b0;
      e_exc   = 1'b0;
    end
    if (e_exc) begin
      m_eear = req_vaddr;
      m_lock = '1;
    end else if (lock_set) begin
      m_lock = lock_set_addr;
    end
    if (tw_en) begin
      if (tw_itable) begin
        if (tw_trans) m_imap[tw_idx] = tw_data; else m_itag[tw_idx] = tw_data;
      end else begin
        if (tw_trans) m_dmap[tw_idx] = tw_data; else m_dtag[tw_idx] = tw_data;
      end
    end
    @(negedge clk);
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk("R9", "exc_valid", 32'(exc_valid), 32'(e_exc));
    chk("R10", "eear", eear, m_eear);
    chk("R10", "lock_addr", lock_addr, m_lock);
    if (e_valid) begin
      chk(cur_tag, "rsp_result", 32'(rsp_result), 32'(e_result));
      chk(cur_tag, "rsp_paddr", rsp_paddr, e_paddr);
      chk(cur_tag, "rsp_rights", 32'(rsp_rights), 32'(e_rights));
      if (e_exc) chk("R9", "exc_code", 32'(exc_code), 32'(e_code));
    end
    req_valid = 1'b0;
    tw_en     = 1'b0;
    lock_set  = 1'b0;
  endtask

  task automatic wr(input logic itab, input logic trans, input int idx, input logic [31:0] d);
    tw_en = 1'b1; tw_itable = itab; tw_trans = trans; tw_idx = 6'(idx); tw_data = d;
    step();
  endtask

  task automatic req(input logic [31:0] va, input logic [1:0] kind, input logic sup,
                     input string tag);
    cur_tag = tag;
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; sup_mode = sup;
    step();
  endtask

  function automatic logic [31:0] tagw(input logic [18:0] vpn, input logic v);
    return {vpn, 12'd0, v};
  endfunction

  function automatic logic [31:0] mapw(input logic [18:0] pfn, input logic [5:0] perm);
    return {pfn, 7'd0, perm};
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [18:0] vpn_a, vpn_b;
    for (int i = 0; i < 64; i++) begin
      m_itag[i] = 'x; m_imap[i] = 'x; m_dtag[i] = 'x; m_dmap[i] = 'x;
    end
    repeat (4) @(negedge clk);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R1", "req_ready in reset", 32'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "exc_valid", 32'(exc_valid), 0);
    chk("R1", "eear", eear, 0);
    chk("R1", "lock_addr", lock_addr, 32'hFFFF_FFFF);
    chk("R2", "req_ready", 32'(req_ready), 1);

    for (int i = 0; i < 64; i++) begin
      wr(1'b0, 1'b0, i, 0); wr(1'b0, 1'b1, i, 0);
      wr(1'b1, 1'b0, i, 0); wr(1'b1, 1'b1, i, 0);
    end

    // bypass: both tables off
    req(32'h1234_5678, 2'b00, 1'b0, "R11");
    req(32'hDEAD_BEEF, 2'b10, 1'b0, "R11");
    itlb_on = 1'b1; dtlb_on = 1'b1;

    vpn_a = 19'h12345;              // index 5
    vpn_b = vpn_a ^ 19'h00040;      // same index, other tag
    wr(1'b0, 1'b0, 5, tagw(vpn_a, 1'b1));
    wr(1'b0, 1'b1, 5, mapw(19'h0ABCD, 6'b001001)); // user read, supervisor read
    req({vpn_a, 13'h0123}, 2'b00, 1'b0, "R8");
    req({vpn_a, 13'h1FFF}, 2'b01, 1'b0, "R6");     // user write denied
    req({vpn_a, 13'h0004}, 2'b01, 1'b1, "R6");     // supervisor write denied
    wr(1'b0, 1'b1, 5, mapw(19'h0ABCD, 6'b010001));
    req({vpn_a, 13'h0004}, 2'b01, 1'b1, "R6");     // supervisor write ok
    req({vpn_a, 13'h0004}, 2'b00, 1'b1, "R6");     // supervisor read denied
    req({vpn_b, 13'h0010}, 2'b00, 1'b0, "R3");     // tag conflict
    req({vpn_b, 13'h0010}, 2'b10, 1'b0, "R3");     // instruction side empty
    wr(1'b0, 1'b0, 5, tagw(vpn_a, 1'b0));
    req({vpn_a, 13'h0010}, 2'b00, 1'b1, "R4");

    // instruction table, and routing by kind bit 1
    wr(1'b1, 1'b0, 5, tagw(vpn_a, 1'b1));
    wr(1'b1, 1'b1, 5, mapw(19'h07777, 6'b100000)); // supervisor execute only
    req({vpn_a, 13'h0ABC}, 2'b10, 1'b1, "R5");
    req({vpn_a, 13'h0ABC}, 2'b10, 1'b0, "R5");
    req({vpn_a, 13'h0ABC}, 2'b11, 1'b1, "R7");
    req({vpn_a, 13'h0ABC}, 2'b00, 1'b1, "R7");     // data side still invalid
    wr(1'b1, 1'b1, 5, mapw(19'h07777, 6'b000100)); // user execute only
    req({vpn_a, 13'h0ABC}, 2'b10, 1'b0, "R5");
    req({vpn_a, 13'h0ABC}, 2'b10, 1'b1, "R5");
    itlb_on = 1'b0;
    req({vpn_a, 13'h0ABC}, 2'b10, 1'b1, "R11");
    req({vpn_b, 13'h0ABC}, 2'b00, 1'b1, "R11");    // data still translated
    itlb_on = 1'b1;

    // write on the same edge as a lookup of that entry
    cur_tag = "R12";
    req_valid = 1'b1; req_vaddr = {vpn_a, 13'h0040}; req_kind = 2'b10; sup_mode = 1'b0;
    tw_en = 1'b1; tw_itable = 1'b1; tw_trans = 1'b1; tw_idx = 6'd5;
    tw_data = mapw(19'h05555, 6'b000000);
    step();
    req({vpn_a, 13'h0040}, 2'b10, 1'b0, "R12");

    // reservation handling
    lock_set = 1'b1; lock_set_addr = 32'h0000_1000;
    step();
    wr(1'b0, 1'b0, 5, tagw(vpn_a, 1'b1));
    req({vpn_a, 13'h0040}, 2'b01, 1'b1, "R10");    // succeeds, reservation kept
    lock_set = 1'b1; lock_set_addr = 32'h0000_2000;
    req({vpn_b, 13'h0777}, 2'b00, 1'b0, "R10");    // fault on same edge wins
    // back-to-back lookups
    req({vpn_a, 13'h0001}, 2'b01, 1'b1, "R2");
    req({vpn_a, 13'h0002}, 2'b00, 1'b0, "R2");

    // random mix over 8 indices and 2 tags each
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 600; n++) begin
      logic [18:0] v;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      v = {12'h0A5, lfsr[6], 3'b000, lfsr[2:0]};
      if (lfsr[9:8] != 2'b00) begin
        cur_tag = "R3";
        req_valid = 1'b1;
        req_vaddr = {v, lfsr[31:19]};
        req_kind  = lfsr[11:10];
        sup_mode  = lfsr[12];
      end
      if (lfsr[14:13] == 2'b00) begin
        tw_en = 1'b1; tw_itable = lfsr[15]; tw_trans = lfsr[16];
        tw_idx = 6'(lfsr[18:17]) | 6'(lfsr[7]) << 2;
        tw_data = lfsr[16] ? {lfsr[28:10], 7'd0, lfsr[5:0]}
                           : {12'h0A5, lfsr[20], 3'b000, lfsr[2:0], 12'd0, lfsr[21] | lfsr[22]};
      end
      if (lfsr[27:25] == 3'b000) begin
        lock_set = 1'b1; lock_set_addr = lfsr;
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule